// File: doc/BRIEF.md
# USB Endpoint Stall Controller

This block holds the halt state for a small group of USB function endpoints. Each endpoint has two stall sources. One is a software-visible stall bit in an 8-bit register. The other is an internal halt flag that the host drives through standard SetFeature(ENDPOINT_HALT) and ClearFeature(ENDPOINT_HALT) requests. When a token addresses an endpoint, the block reports on a one-cycle strobe whether that transaction must be answered with a STALL handshake.

The two sources are linked in three ways:
- A STALL sent because of the register bit also latches the endpoint's halt flag. After that, only the host can cancel the stall.
- A ClearFeature that arrives while the register bit is still set leaves the flag set.
- An optional auto-clear mode drops the register bit once a STALL has been issued for that endpoint, so software does not need to clear it.

The register bits are also cleared by a function-level soft reset. A plain register write port sets them, and the register can be read back at any time. Packet encoding, PID and CRC handling, data FIFOs and setup-packet decoding are handled outside this block.

Top module: `ep_stall_top`

## Requirements
- R1: Register bit n+1 is the stall bit of endpoint n, for endpoints 0 to 5. Bits 0 and 7 always read 0 and ignore writes. A write stores wrData in the next cycle, and rdData always shows the current register.
- R2: A token strobe (tokValid high, tokEp below 6) to an endpoint whose register bit is 1 drives stallHs high for exactly the one cycle after the strobe.
- R3: A token to an endpoint with neither its register bit nor its halt flag set gives no stall. Tokens and feature requests for endpoint numbers 6 and 7 have no effect.
- R4: A host SetFeature (featValid high, featSet=1) sets the endpoint's halt flag. Later tokens to that endpoint then stall, even when its register bit is 0.
- R5: A host ClearFeature (featValid high, featSet=0) clears the endpoint's halt flag when its register bit is 0. Later tokens to that endpoint then get no stall.
- R6: A STALL issued while the register bit is 1 also sets the halt flag. Tokens to that endpoint keep stalling after software clears the bit, until a ClearFeature arrives.
- R7: A ClearFeature that arrives while the endpoint's register bit is 1 leaves the halt flag set. Tokens still stall after software later clears the bit.
- R8: When autoClrEn is 1, the register bit of a stalled endpoint reads 0 in the cycle after the token. When autoClrEn is 0, the bit keeps its value.
- R9: If a register write and an auto-clear hit the same bit in the same cycle, the written value is kept.
- R10: If a ClearFeature and a STALL-driven halt set hit the same flag in the same cycle, the flag ends up set.
- R11: System reset clears the register and all halt flags. softRst clears the register and takes priority over a write in the same cycle, but leaves the halt flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register value, reserved bits 0 |
| tokValid | input | 1 | Token received strobe |
| tokEp | input | 3 | Endpoint number of the token |
| featValid | input | 1 | Host halt feature request strobe |
| featSet | input | 1 | 1 = SetFeature(halt), 0 = ClearFeature(halt) |
| featEp | input | 3 | Endpoint number of the feature request |
| autoClrEn | input | 1 | Auto-clear mode enable |
| softRst | input | 1 | Function soft reset of the register |
| stallHs | output | 1 | Answer the token of the previous cycle with STALL |

## Verification
The following are checked by assertions on every cycle:
- reserved bits reading 0;
- a register-bit stall answering its token in the following cycle, and no stall without a token;
- out-of-range tokens being silent;
- write-wins and soft-reset priority;
- auto-clear;
- the register holding when nothing touches it.

The halt flag is not visible at the ports, so its behaviour can only be shown by the bench's token sequences. Those sequences cover flag latching by a STALL, ClearFeature being suppressed while the register bit is set, host-only cancellation, and the flag surviving a soft reset but not a system reset.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  localparam int NUM_EP  = 6;
  localparam int REG_W   = 8;
  localparam int EP_W    = 3;
  localparam int BIT_OFS = 1;
  localparam logic [REG_W-1:0] REG_MASK = REG_W'(((1 << NUM_EP) - 1) << BIT_OFS);

  typedef struct packed {
    logic [NUM_EP-1:0] tokHit;
    logic [NUM_EP-1:0] featSetHit;
    logic [NUM_EP-1:0] featClrHit;
    logic              wrEn;
    logic [NUM_EP-1:0] wrBits;
    logic              softRst;
    logic              autoClr;
  } stall_strb_t;
endpackage

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl
  import ep_stall_pkg::*;
(
  input  logic             tokValid,
  input  logic [EP_W-1:0]  tokEp,
  input  logic             featValid,
  input  logic             featSet,
  input  logic [EP_W-1:0]  featEp,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             softRst,
  input  logic             autoClrEn,
  output stall_strb_t      strb
);
  logic unusedWrBits;
  assign unusedWrBits = ^(wrData & ~REG_MASK);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign strb.tokHit[i]     = tokValid && (tokEp == EP_W'(i));
    assign strb.featSetHit[i] = featValid && featSet && (featEp == EP_W'(i));
    assign strb.featClrHit[i] = featValid && !featSet && (featEp == EP_W'(i));
  end

  assign strb.wrEn    = wrEn;
  assign strb.wrBits  = wrData[BIT_OFS +: NUM_EP];
  assign strb.softRst = softRst;
  assign strb.autoClr = autoClrEn;
endmodule

// File: rtl/ep_stall_slice.sv
module ep_stall_slice (
  input  logic clk,
  input  logic rstN,
  input  logic tokHit,
  input  logic featSetHit,
  input  logic featClrHit,
  input  logic wrEn,
  input  logic wrBit,
  input  logic softRst,
  input  logic autoClr,
  output logic regBit,
  output logic respond
);
  logic haltFlag;
  logic haltSet;

  assign respond = tokHit && (regBit || haltFlag);
  // a clear that arrives while the register bit is set re-asserts the flag
  assign haltSet = featSetHit || (tokHit && regBit) || (featClrHit && regBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   regBit <= 1'b0;
    else if (softRst)            regBit <= 1'b0;
    else if (wrEn)               regBit <= wrBit;
    else if (autoClr && respond) regBit <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           haltFlag <= 1'b0;
    else if (haltSet)    haltFlag <= 1'b1;
    else if (featClrHit) haltFlag <= 1'b0;
  end
endmodule

// File: rtl/ep_stall_dp.sv
module ep_stall_dp
  import ep_stall_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stall_strb_t      strb,
  output logic             stallHs,
  output logic [REG_W-1:0] readData
);
  logic [NUM_EP-1:0] regBits;
  logic [NUM_EP-1:0] respond;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_stall_slice u_slice (
      .clk        (clk),
      .rstN       (rstN),
      .tokHit     (strb.tokHit[i]),
      .featSetHit (strb.featSetHit[i]),
      .featClrHit (strb.featClrHit[i]),
      .wrEn       (strb.wrEn),
      .wrBit      (strb.wrBits[i]),
      .softRst    (strb.softRst),
      .autoClr    (strb.autoClr),
      .regBit     (regBits[i]),
      .respond    (respond[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallHs <= 1'b0;
    else       stallHs <= |respond;
  end

  assign readData = REG_W'(regBits) << BIT_OFS;
endmodule

// File: rtl/ep_stall_top.sv
module ep_stall_top
  import ep_stall_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             tokValid,
  input  logic [EP_W-1:0]  tokEp,
  input  logic             featValid,
  input  logic             featSet,
  input  logic [EP_W-1:0]  featEp,
  input  logic             autoClrEn,
  input  logic             softRst,
  output logic             stallHs
);
  stall_strb_t strb;

  ep_stall_ctrl u_ctrl (
    .tokValid  (tokValid),
    .tokEp     (tokEp),
    .featValid (featValid),
    .featSet   (featSet),
    .featEp    (featEp),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .softRst   (softRst),
    .autoClrEn (autoClrEn),
    .strb      (strb)
  );

  ep_stall_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stallHs  (stallHs),
    .readData (rdData)
  );
endmodule

// File: rtl/ep_stall_chk.sv
module ep_stall_chk
  import ep_stall_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             tokValid,
  input logic [EP_W-1:0]  tokEp,
  input logic             autoClrEn,
  input logic             softRst,
  input logic             stallHs
);
  logic [EP_W-1:0] tokBit;
  logic            tokInRange;
  assign tokBit     = tokEp + EP_W'(BIT_OFS);
  assign tokInRange = (int'(tokEp) < NUM_EP);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~REG_MASK) == '0);

  p_reg_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && tokInRange && rdData[tokBit] |=> stallHs);

  p_stall_needs_token_r2: assert property (@(posedge clk) disable iff (!rstN)
    stallHs |-> $past(tokValid));

  p_out_of_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && !tokInRange |=> !stallHs);

  p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    tokValid && tokInRange && rdData[tokBit] && autoClrEn && !wrEn && !softRst
    |=> !rdData[$past(tokBit)]);

  p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !softRst && !(autoClrEn && tokValid) |=> $stable(rdData));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !softRst |=> rdData == ($past(wrData) & REG_MASK));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> rdData == '0);
endmodule

bind ep_stall_top ep_stall_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .tokValid  (tokValid),
  .tokEp     (tokEp),
  .autoClrEn (autoClrEn),
  .softRst   (softRst),
  .stallHs   (stallHs)
);

// File: tb/ep_stall_top_tb_top.sv
module ep_stall_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 53;

  // {req[3:0], wr, wd[7:0], tok, tep[2:0], fv, fs, fep[2:0], ac, sr, expStall, expRd[7:0]}
  localparam logic [32:0] VECS [NV] = '{
    {4'd1,  1'b1,8'hFF, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h7E}, // R1 reserved bits dropped
    {4'd1,  1'b1,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R1
    {4'd3,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R3 nothing set
    {4'd2,  1'b1,8'h08, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h08}, // R2 ep2 bit
    {4'd2,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h08}, // R2 stall
    {4'd2,  1'b0,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h08}, // R2 one cycle only
    {4'd6,  1'b1,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R6 software clears
    {4'd6,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h00}, // R6 flag latched
    {4'd5,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd2, 1'b0,1'b0, 1'b0,8'h00}, // R5 clear ep2
    {4'd5,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd4,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b1,3'd4, 1'b0,1'b0, 1'b0,8'h00}, // R4 set ep4
    {4'd4,  1'b0,8'h00, 1'b1,3'd4, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h00}, // R4
    {4'd3,  1'b0,8'h00, 1'b1,3'd7, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R3 ep7
    {4'd3,  1'b0,8'h00, 1'b1,3'd6, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R3 ep6
    {4'd5,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd4, 1'b0,1'b0, 1'b0,8'h00}, // R5 clear ep4
    {4'd5,  1'b0,8'h00, 1'b1,3'd4, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd7,  1'b1,8'h02, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h02}, // R7 ep0 bit
    {4'd7,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h02}, // R7 clear while set
    {4'd7,  1'b1,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R7
    {4'd7,  1'b0,8'h00, 1'b1,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h00}, // R7 still stalls
    {4'd5,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd5,  1'b0,8'h00, 1'b1,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd8,  1'b1,8'h40, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h40}, // R8 ep5 bit
    {4'd8,  1'b0,8'h00, 1'b1,3'd5, 1'b0,1'b0,3'd0, 1'b1,1'b0, 1'b1,8'h00}, // R8 auto-clear
    {4'd6,  1'b0,8'h00, 1'b1,3'd5, 1'b0,1'b0,3'd0, 1'b1,1'b0, 1'b1,8'h00}, // R6 flag holds
    {4'd5,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd5, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd5,  1'b0,8'h00, 1'b1,3'd5, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd9,  1'b1,8'h20, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h20}, // R9 ep4 bit
    {4'd9,  1'b1,8'h20, 1'b1,3'd4, 1'b0,1'b0,3'd0, 1'b1,1'b0, 1'b1,8'h20}, // R9 write wins
    {4'd9,  1'b1,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R9
    {4'd9,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd4, 1'b0,1'b0, 1'b0,8'h00}, // R9
    {4'd9,  1'b0,8'h00, 1'b1,3'd4, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R9
    {4'd10, 1'b1,8'h04, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h04}, // R10 ep1 bit
    {4'd10, 1'b0,8'h00, 1'b1,3'd1, 1'b1,1'b0,3'd1, 1'b1,1'b0, 1'b1,8'h00}, // R10 set vs clear
    {4'd10, 1'b0,8'h00, 1'b1,3'd1, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h00}, // R10 set won
    {4'd5,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd1, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd5,  1'b0,8'h00, 1'b1,3'd1, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R5
    {4'd11, 1'b1,8'h10, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h10}, // R11 ep3 bit
    {4'd11, 1'b0,8'h00, 1'b1,3'd3, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h10}, // R11
    {4'd11, 1'b0,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b1, 1'b0,8'h00}, // R11 soft reset
    {4'd11, 1'b0,8'h00, 1'b1,3'd3, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h00}, // R11 flag kept
    {4'd11, 1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd3, 1'b0,1'b0, 1'b0,8'h00}, // R11
    {4'd11, 1'b0,8'h00, 1'b1,3'd3, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R11
    {4'd11, 1'b1,8'h7E, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b1, 1'b0,8'h00}, // R11 soft reset over write
    {4'd8,  1'b1,8'h08, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h08}, // R8
    {4'd8,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b1,8'h08}, // R8 mode off keeps bit
    {4'd8,  1'b1,8'h00, 1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R8
    {4'd8,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b0,3'd2, 1'b0,1'b0, 1'b0,8'h00}, // R8
    {4'd8,  1'b0,8'h00, 1'b1,3'd2, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R8
    {4'd3,  1'b0,8'h00, 1'b0,3'd0, 1'b1,1'b1,3'd7, 1'b0,1'b0, 1'b0,8'h00}, // R3 set ep7 ignored
    {4'd3,  1'b0,8'h00, 1'b1,3'd5, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R3
    {4'd3,  1'b0,8'h00, 1'b1,3'd0, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}, // R3
    {4'd3,  1'b0,8'h00, 1'b1,3'd7, 1'b0,1'b0,3'd0, 1'b0,1'b0, 1'b0,8'h00}  // R3
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tokValid = 1'b0;
  logic [2:0] tokEp = '0;
  logic       featValid = 1'b0;
  logic       featSet = 1'b0;
  logic [2:0] featEp = '0;
  logic       autoClrEn = 1'b0;
  logic       softRst = 1'b0;
  logic       stallHs;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_stall_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .tokValid(tokValid), .tokEp(tokEp), .featValid(featValid), .featSet(featSet),
    .featEp(featEp), .autoClrEn(autoClrEn), .softRst(softRst), .stallHs(stallHs)
  );

  task automatic check(input int req, input int idx, input logic expS, input logic [7:0] expRd);
    nChecks++;
    if (stallHs !== expS || rdData !== expRd) begin
      nFails++;
      $display("FAIL R%0d step %0d: stallHs=%0b rdData=%02h, expected stallHs=%0b rdData=%02h",
               req, idx, stallHs, rdData, expS, expRd);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; wrData = '0; tokValid = 1'b0; tokEp = '0;
    featValid = 1'b0; featSet = 1'b0; featEp = '0; autoClrEn = 1'b0; softRst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL R0 watchdog: run still busy, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check(11, -1, 1'b0, 8'h00); // R11 reset state
    rstN = 1'b1;
    @(negedge clk);
    check(11, -2, 1'b0, 8'h00); // R11 after release

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VECS[i];
      wrEn      = v[28];
      wrData    = v[27:20];
      tokValid  = v[19];
      tokEp     = v[18:16];
      featValid = v[15];
      featSet   = v[14];
      featEp    = v[13:11];
      autoClrEn = v[10];
      softRst   = v[9];
      @(negedge clk);
      check(int'(v[32:29]), i, v[8], v[7:0]);
    end

    // R11 system reset clears the register and the halt flags
    idle(); wrEn = 1'b1; wrData = 8'h7E;
    @(negedge clk); idle(); tokValid = 1'b1; tokEp = 3'd0;
    @(negedge clk); idle();
    check(11, 100, 1'b1, 8'h7E);
    rstN = 1'b0;
    @(negedge clk);
    check(11, 101, 1'b0, 8'h00);
    rstN = 1'b1;
    tokValid = 1'b1; tokEp = 3'd0;
    @(negedge clk); idle();
    check(11, 102, 1'b0, 8'h00); // R11 flag gone after system reset

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule